// File: doc/BRIEF.md
# Instruction Bundle Decode and Dispatch

This block sits between instruction fetch and the execution back end of a wide-issue processor. Each cycle it may take one 160-bit bundle made of five 32-bit slots. It holds that bundle in a single register and reads a 3-bit class code from the top of every slot. Each occupied slot is then steered to a port of the unit that serves its class: the scalar pipeline, the load side or store side of the vector memory unit, the vector execute pipeline, or the matrix pipeline.

Slots are not tied to a unit. Any slot may carry any class, and several slots may name the same class. Within a class, instructions take that class's ports in rising slot order. A bundle only ever issues whole. The block raises port valids only in the cycle when every port the bundle needs is ready. Until then it keeps the bundle and refuses new input. Slots are trusted to be independent, so no hazard check is made between them.

A control state machine has two states. EMPTY means no bundle is held. HELD means a bundle waits to issue. The transitions are:
- ACCEPT: EMPTY to HELD when input is valid.
- RETIRE: HELD to EMPTY when the bundle leaves and no new one arrives.
- REFILL: HELD to HELD when the bundle leaves and the next one is taken in the same cycle.
- WAIT: HELD to HELD while the bundle cannot leave.

Top module: `bundle_dispatch`

## Requirements
- R1: After reset no port valid is high, the error output is low and the input ready is high.
- R2: A bundle is taken on a clock edge where input valid and input ready are both high. While a bundle is held and cannot leave, input ready is low and further input is ignored.
- R3: Bits [31:29] of a slot give its class: 000 empty, 001 scalar, 010 vector load, 011 vector store, 100 vector execute, 101 matrix. Each occupied slot appears on a port of its class with its full 32-bit word and its 3-bit slot number.
- R4: Within one class, the lowest-numbered slot of that class goes to port 0, the next to port 1, and so on.
- R5: Slots with class 000 are never presented on any port. A bundle of only such slots leaves in its first held cycle with no valid and no error.
- R6: Port valids are all low unless every port the held bundle needs is ready. In that cycle exactly the needed ports are valid.
- R7: A held bundle containing class 110 or 111 leaves in its first held cycle with no port valid. The error output is high for that one cycle.
- R8: Port counts are 2 scalar, 2 vector load, 1 vector store, 1 vector execute and 1 matrix. A bundle needing more ports of any class than exist is treated like R7: it is dropped with the error output high for one cycle.
- R9: In the cycle a held bundle leaves, input ready is high, so the next bundle can follow with no gap.
- R10: The earliest a bundle can appear on ports is the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch offers a bundle |
| in_ready | output | 1 | Block can take a bundle this cycle |
| in_bundle | input | 160 | Five 32-bit slots, slot 0 in bits [31:0] |
| sc_valid | output | 2 | Scalar port valids |
| sc_ready | input | 2 | Scalar port readies |
| sc_instr | output | 64 | Scalar port words, port 0 low |
| sc_slot | output | 6 | Scalar port slot numbers, 3 bits each |
| ld_valid | output | 2 | Vector load port valids |
| ld_ready | input | 2 | Vector load port readies |
| ld_instr | output | 64 | Vector load port words |
| ld_slot | output | 6 | Vector load port slot numbers |
| st_valid | output | 1 | Vector store port valid |
| st_ready | input | 1 | Vector store port ready |
| st_instr | output | 32 | Vector store port word |
| st_slot | output | 3 | Vector store port slot number |
| vx_valid | output | 1 | Vector execute port valid |
| vx_ready | input | 1 | Vector execute port ready |
| vx_instr | output | 32 | Vector execute port word |
| vx_slot | output | 3 | Vector execute port slot number |
| mx_valid | output | 1 | Matrix port valid |
| mx_ready | input | 1 | Matrix port ready |
| mx_instr | output | 32 | Matrix port word |
| mx_slot | output | 3 | Matrix port slot number |
| err_pulse | output | 1 | High for the cycle a bad bundle is dropped |

## Verification
Random bundles weight the classes so that empty slots, repeated classes and over-subscribed classes all occur often. This separates correct ascending port assignment from order mix-ups and catches count limits that are off by one. Random ready patterns, including a single missing ready, tell whole-bundle issue apart from partial issue. Directed bundles cover a bundle of only empty slots, a mixed memory-heavy bundle, two scalars placed out of order, an illegal code, three scalars, and a second bundle offered while the first is stalled. Together these separate the drop-with-error path, the no-op path and the back-to-back refill path.

// File: rtl/bdd_pkg.sv
package bdd_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_EMPTY  = 3'b000,
        CLS_SCALAR = 3'b001,
        CLS_VLOAD  = 3'b010,
        CLS_VSTORE = 3'b011,
        CLS_VEXEC  = 3'b100,
        CLS_MATRIX = 3'b101,
        CLS_BAD_A  = 3'b110,
        CLS_BAD_B  = 3'b111
    } slot_cls_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } hold_state_e;

endpackage

// File: rtl/slot_classify.sv
module slot_classify
    import bdd_pkg::*;
#(
    parameter int NUM_SLOTS = 5
) (
    input  logic [NUM_SLOTS*CLS_W-1:0] cls_field,
    output logic [NUM_SLOTS-1:0]       hit_sc,
    output logic [NUM_SLOTS-1:0]       hit_ld,
    output logic [NUM_SLOTS-1:0]       hit_st,
    output logic [NUM_SLOTS-1:0]       hit_vx,
    output logic [NUM_SLOTS-1:0]       hit_mx,
    output logic                       any_bad
);

    logic [NUM_SLOTS-1:0] bad_vec;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        slot_cls_e code;
        assign code = slot_cls_e'(cls_field[s*CLS_W +: CLS_W]);

        always_comb begin
            hit_sc[s]  = 1'b0;
            hit_ld[s]  = 1'b0;
            hit_st[s]  = 1'b0;
            hit_vx[s]  = 1'b0;
            hit_mx[s]  = 1'b0;
            bad_vec[s] = 1'b0;
            unique case (code)
                CLS_EMPTY:  ;
                CLS_SCALAR: hit_sc[s] = 1'b1;
                CLS_VLOAD:  hit_ld[s] = 1'b1;
                CLS_VSTORE: hit_st[s] = 1'b1;
                CLS_VEXEC:  hit_vx[s] = 1'b1;
                CLS_MATRIX: hit_mx[s] = 1'b1;
                CLS_BAD_A,
                CLS_BAD_B:  bad_vec[s] = 1'b1;
            endcase
        end
    end

    assign any_bad = |bad_vec;

endmodule

// File: rtl/class_port_alloc.sv
module class_port_alloc #(
    parameter int NUM_SLOTS = 5,
    parameter int SLOT_W    = 32,
    parameter int IDX_W     = 3,
    parameter int NPORTS    = 2
) (
    input  logic [NUM_SLOTS-1:0]        hit,
    input  logic [NUM_SLOTS*SLOT_W-1:0] bundle,
    output logic [NPORTS-1:0]           need,
    output logic [NPORTS*SLOT_W-1:0]    word,
    output logic [NPORTS*IDX_W-1:0]     idx,
    output logic                        over
);

    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    logic [CNT_W-1:0] used;

    always_comb begin
        need = '0;
        word = '0;
        idx  = '0;
        used = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (hit[s]) begin
                for (int p = 0; p < NPORTS; p++) begin
                    if (used == CNT_W'(p)) begin
                        need[p]                  = 1'b1;
                        word[p*SLOT_W +: SLOT_W] = bundle[s*SLOT_W +: SLOT_W];
                        idx[p*IDX_W +: IDX_W]    = IDX_W'(s);
                    end
                end
                used = used + CNT_W'(1);
            end
        end
        over = (used > CNT_W'(NPORTS));
    end

endmodule

// File: rtl/bundle_dispatch.sv
module bundle_dispatch
    import bdd_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int SLOT_W    = 32,
    parameter int IDX_W     = 3,
    parameter int N_SC      = 2,
    parameter int N_LD      = 2,
    parameter int N_ST      = 1,
    parameter int N_VX      = 1,
    parameter int N_MX      = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [NUM_SLOTS*SLOT_W-1:0] in_bundle,
    output logic [N_SC-1:0]             sc_valid,
    input  logic [N_SC-1:0]             sc_ready,
    output logic [N_SC*SLOT_W-1:0]      sc_instr,
    output logic [N_SC*IDX_W-1:0]       sc_slot,
    output logic [N_LD-1:0]             ld_valid,
    input  logic [N_LD-1:0]             ld_ready,
    output logic [N_LD*SLOT_W-1:0]      ld_instr,
    output logic [N_LD*IDX_W-1:0]       ld_slot,
    output logic [N_ST-1:0]             st_valid,
    input  logic [N_ST-1:0]             st_ready,
    output logic [N_ST*SLOT_W-1:0]      st_instr,
    output logic [N_ST*IDX_W-1:0]       st_slot,
    output logic [N_VX-1:0]             vx_valid,
    input  logic [N_VX-1:0]             vx_ready,
    output logic [N_VX*SLOT_W-1:0]      vx_instr,
    output logic [N_VX*IDX_W-1:0]       vx_slot,
    output logic [N_MX-1:0]             mx_valid,
    input  logic [N_MX-1:0]             mx_ready,
    output logic [N_MX*SLOT_W-1:0]      mx_instr,
    output logic [N_MX*IDX_W-1:0]       mx_slot,
    output logic                        err_pulse
);

    localparam int BUNDLE_W = NUM_SLOTS * SLOT_W;

    hold_state_e           state_q, state_d;
    logic [BUNDLE_W-1:0]   bundle_q;
    logic [NUM_SLOTS*CLS_W-1:0] cls_field;

    logic [NUM_SLOTS-1:0]  hit_sc, hit_ld, hit_st, hit_vx, hit_mx;
    logic                  code_bad;
    logic [N_SC-1:0]       need_sc;
    logic [N_LD-1:0]       need_ld;
    logic [N_ST-1:0]       need_st;
    logic [N_VX-1:0]       need_vx;
    logic [N_MX-1:0]       need_mx;
    logic                  over_sc, over_ld, over_st, over_vx, over_mx;
    logic                  bundle_bad, all_ready, fire, retire, held;

    // Class field of every held slot
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_field
        assign cls_field[s*CLS_W +: CLS_W] = bundle_q[s*SLOT_W + SLOT_W - CLS_W +: CLS_W];
    end

    slot_classify #(.NUM_SLOTS(NUM_SLOTS)) u_classify (
        .cls_field (cls_field),
        .hit_sc    (hit_sc),
        .hit_ld    (hit_ld),
        .hit_st    (hit_st),
        .hit_vx    (hit_vx),
        .hit_mx    (hit_mx),
        .any_bad   (code_bad)
    );

    class_port_alloc #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .NPORTS(N_SC)) u_alloc_sc (
        .hit(hit_sc), .bundle(bundle_q), .need(need_sc), .word(sc_instr), .idx(sc_slot), .over(over_sc));
    class_port_alloc #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .NPORTS(N_LD)) u_alloc_ld (
        .hit(hit_ld), .bundle(bundle_q), .need(need_ld), .word(ld_instr), .idx(ld_slot), .over(over_ld));
    class_port_alloc #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .NPORTS(N_ST)) u_alloc_st (
        .hit(hit_st), .bundle(bundle_q), .need(need_st), .word(st_instr), .idx(st_slot), .over(over_st));
    class_port_alloc #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .NPORTS(N_VX)) u_alloc_vx (
        .hit(hit_vx), .bundle(bundle_q), .need(need_vx), .word(vx_instr), .idx(vx_slot), .over(over_vx));
    class_port_alloc #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .NPORTS(N_MX)) u_alloc_mx (
        .hit(hit_mx), .bundle(bundle_q), .need(need_mx), .word(mx_instr), .idx(mx_slot), .over(over_mx));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Bundle holding register
    always_ff @(posedge clk) begin
        if (!rst_n)                    bundle_q <= '0;
        else if (in_valid && in_ready) bundle_q <= in_bundle;
    end

    // Issue decision
    always_comb begin
        held       = (state_q == ST_HELD);
        bundle_bad = code_bad | over_sc | over_ld | over_st | over_vx | over_mx;
        all_ready  = (&(sc_ready | ~need_sc)) & (&(ld_ready | ~need_ld)) &
                     (&(st_ready | ~need_st)) & (&(vx_ready | ~need_vx)) &
                     (&(mx_ready | ~need_mx));
        fire       = held & ~bundle_bad & all_ready;
        retire     = held & (bundle_bad | all_ready);
    end

    // Next state: ACCEPT, RETIRE, REFILL, WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)            state_d = ST_HELD;
            ST_HELD:  if (retire && !in_valid) state_d = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        err_pulse = 1'b0;
        sc_valid  = '0;
        ld_valid  = '0;
        st_valid  = '0;
        vx_valid  = '0;
        mx_valid  = '0;
        unique case (state_q)
            ST_EMPTY: in_ready = 1'b1;
            ST_HELD: begin
                in_ready  = retire;
                err_pulse = bundle_bad;
                if (fire) begin
                    sc_valid = need_sc;
                    ld_valid = need_ld;
                    st_valid = need_st;
                    vx_valid = need_vx;
                    mx_valid = need_mx;
                end
            end
        endcase
    end

endmodule

// File: rtl/bundle_dispatch_chk.sv
module bundle_dispatch_chk #(
    parameter int SLOT_W = 32,
    parameter int IDX_W  = 3,
    parameter int N_SC   = 2,
    parameter int N_LD   = 2,
    parameter int N_ST   = 1,
    parameter int N_VX   = 1,
    parameter int N_MX   = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_ready,
    input logic                   err_pulse,
    input logic [N_SC-1:0]        sc_valid,
    input logic [N_SC-1:0]        sc_ready,
    input logic [N_SC*SLOT_W-1:0] sc_instr,
    input logic [N_SC*IDX_W-1:0]  sc_slot,
    input logic [N_LD-1:0]        ld_valid,
    input logic [N_LD-1:0]        ld_ready,
    input logic [N_LD*SLOT_W-1:0] ld_instr,
    input logic [N_LD*IDX_W-1:0]  ld_slot,
    input logic [N_ST-1:0]        st_valid,
    input logic [N_ST-1:0]        st_ready,
    input logic [N_VX-1:0]        vx_valid,
    input logic [N_VX-1:0]        vx_ready,
    input logic [N_MX-1:0]        mx_valid,
    input logic [N_MX-1:0]        mx_ready
);

    logic [N_SC+N_LD+N_ST+N_VX+N_MX-1:0] all_v, all_r;
    assign all_v = {mx_valid, vx_valid, st_valid, ld_valid, sc_valid};
    assign all_r = {mx_ready, vx_ready, st_ready, ld_ready, sc_ready};

    // R6: no port is presented unless it is ready
    a_r6_valid_has_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (all_v & ~all_r) == '0);

    // R7: a dropped bundle presents nothing
    a_r7_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (all_v == '0));

    // R9: leaving frees the input in the same cycle
    a_r9_retire_frees_input: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse || (|all_v)) |-> in_ready);

    for (genvar p = 0; p < N_SC; p++) begin : g_sc
        // R3: scalar ports carry scalar class only
        a_r3_sc_class: assert property (@(posedge clk) disable iff (!rst_n)
            sc_valid[p] |-> (sc_instr[p*SLOT_W + SLOT_W - 3 +: 3] == 3'b001));
        if (p > 0) begin : g_ord
            // R4: ports fill from 0 upward in rising slot order
            a_r4_sc_order: assert property (@(posedge clk) disable iff (!rst_n)
                sc_valid[p] |-> (sc_valid[p-1] &&
                    (sc_slot[p*IDX_W +: IDX_W] > sc_slot[(p-1)*IDX_W +: IDX_W])));
        end
    end

    for (genvar p = 0; p < N_LD; p++) begin : g_ld
        // R3: load ports carry vector load class only
        a_r3_ld_class: assert property (@(posedge clk) disable iff (!rst_n)
            ld_valid[p] |-> (ld_instr[p*SLOT_W + SLOT_W - 3 +: 3] == 3'b010));
        if (p > 0) begin : g_ord
            // R4: ascending slot order on the load ports
            a_r4_ld_order: assert property (@(posedge clk) disable iff (!rst_n)
                ld_valid[p] |-> (ld_valid[p-1] &&
                    (ld_slot[p*IDX_W +: IDX_W] > ld_slot[(p-1)*IDX_W +: IDX_W])));
        end
    end

endmodule

bind bundle_dispatch bundle_dispatch_chk #(
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .N_SC(N_SC), .N_LD(N_LD),
    .N_ST(N_ST), .N_VX(N_VX), .N_MX(N_MX)
) i_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .err_pulse(err_pulse),
    .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_instr(sc_instr), .sc_slot(sc_slot),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_instr(ld_instr), .ld_slot(ld_slot),
    .st_valid(st_valid), .st_ready(st_ready), .vx_valid(vx_valid), .vx_ready(vx_ready),
    .mx_valid(mx_valid), .mx_ready(mx_ready)
);

// File: tb/test_bundle_dispatch.sv
`timescale 1ns/1ps
module test_bundle_dispatch;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [159:0] in_bundle = '0;
    logic [1:0]   sc_valid, ld_valid;
    logic [0:0]   st_valid, vx_valid, mx_valid;
    logic [1:0]   sc_ready, ld_ready;
    logic [0:0]   st_ready, vx_ready, mx_ready;
    logic [63:0]  sc_instr, ld_instr;
    logic [31:0]  st_instr, vx_instr, mx_instr;
    logic [5:0]   sc_slot, ld_slot;
    logic [2:0]   st_slot, vx_slot, mx_slot;
    logic         err_pulse;

    logic [6:0]   rdy = '0;
    assign {mx_ready, vx_ready, st_ready, ld_ready, sc_ready} = rdy;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model results: port order sc0 sc1 ld0 ld1 st vx mx
    logic [6:0] m_need;
    logic       m_bad;
    int         m_slot [7];

    always #5 clk = ~clk;

    bundle_dispatch i_bundle_dispatch (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bundle(in_bundle),
        .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_instr(sc_instr), .sc_slot(sc_slot),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_instr(ld_instr), .ld_slot(ld_slot),
        .st_valid(st_valid), .st_ready(st_ready), .st_instr(st_instr), .st_slot(st_slot),
        .vx_valid(vx_valid), .vx_ready(vx_ready), .vx_instr(vx_instr), .vx_slot(vx_slot),
        .mx_valid(mx_valid), .mx_ready(mx_ready), .mx_instr(mx_instr), .mx_slot(mx_slot),
        .err_pulse(err_pulse)
    );

    function automatic logic [6:0] all_valid();
        return {mx_valid, vx_valid, st_valid, ld_valid, sc_valid};
    endfunction

    function automatic logic [34:0] port_out(int p);
        case (p)
            0: return {sc_instr[31:0],  sc_slot[2:0]};
            1: return {sc_instr[63:32], sc_slot[5:3]};
            2: return {ld_instr[31:0],  ld_slot[2:0]};
            3: return {ld_instr[63:32], ld_slot[5:3]};
            4: return {st_instr, st_slot};
            5: return {vx_instr, vx_slot};
            default: return {mx_instr, mx_slot};
        endcase
    endfunction

    // Reference model from R3, R4, R7, R8
    task automatic model(input logic [159:0] b);
        int base [5] = '{0, 2, 4, 5, 6};
        int cap  [5] = '{2, 2, 1, 1, 1};
        int cnt  [5] = '{0, 0, 0, 0, 0};
        m_need = '0;
        m_bad  = 1'b0;
        for (int p = 0; p < 7; p++) m_slot[p] = 0;
        for (int s = 0; s < 5; s++) begin
            logic [2:0] c;
            int k;
            c = b[s*32+29 +: 3];
            k = -1;
            case (c)
                3'd1: k = 0;
                3'd2: k = 1;
                3'd3: k = 2;
                3'd4: k = 3;
                3'd5: k = 4;
                3'd6, 3'd7: m_bad = 1'b1;
                default: k = -1;
            endcase
            if (k >= 0) begin
                if (cnt[k] < cap[k]) begin
                    m_need[base[k] + cnt[k]] = 1'b1;
                    m_slot[base[k] + cnt[k]] = s;
                end
                cnt[k]++;
            end
        end
        for (int k = 0; k < 5; k++) if (cnt[k] > cap[k]) m_bad = 1'b1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [159:0] make_bundle(input logic [2:0] c0, c1, c2, c3, c4);
        logic [2:0]   cs [5] = '{c0, c1, c2, c3, c4};
        logic [159:0] b;
        for (int s = 0; s < 5; s++) b[s*32 +: 32] = {cs[s], 29'($urandom)};
        return b;
    endfunction

    function automatic logic [159:0] rand_bundle();
        logic [159:0] b;
        for (int s = 0; s < 5; s++) begin
            int r;
            logic [2:0] c;
            r = int'($urandom % 48);
            if (r == 47)     c = 3'(6 + ($urandom % 2));
            else if (r % 8 >= 6) c = 3'd0;
            else             c = 3'(r % 8);
            b[s*32 +: 32] = {c, 29'($urandom)};
        end
        return b;
    endfunction

    // Check the held-cycle outputs against the model for the given readies
    task automatic check_held(input logic [159:0] b, input string tag, output bit left);
        logic [6:0] ev;
        bit fire;
        fire = !m_bad && ((m_need & ~rdy) == '0);
        ev   = fire ? m_need : 7'd0;
        left = m_bad || fire;
        chk(all_valid() == ev, tag, "R6 port valids", 64'(all_valid()), 64'(ev));
        chk(err_pulse == m_bad, tag, "R7/R8 error", 64'(err_pulse), 64'(m_bad));
        chk(in_ready == left, tag, "R9 input ready", 64'(in_ready), 64'(left));
        for (int p = 0; p < 7; p++) begin
            if (ev[p]) begin
                logic [34:0] exp_o;
                exp_o = {b[m_slot[p]*32 +: 32], 3'(m_slot[p])};
                chk(port_out(p) == exp_o, tag, $sformatf("R3/R4 port %0d word+slot", p),
                    64'(port_out(p)), 64'(exp_o));
            end
        end
    endtask

    // Issue one bundle: offer, hold with first_rdy, then release all readies
    task automatic run_one(input logic [159:0] b, input logic [6:0] first_rdy, input string tag);
        bit left;
        @(negedge clk);
        in_bundle = b;
        in_valid  = 1'b1;
        rdy       = 7'h7f;
        #1;
        chk(in_ready == 1'b1, tag, "R2 ready when empty", 64'(in_ready), 64'd1);
        chk(all_valid() == '0, tag, "R10 nothing before acceptance", 64'(all_valid()), 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rdy      = first_rdy;
        model(b);
        #1;
        check_held(b, tag, left);
        if (!left) begin
            @(negedge clk);
            rdy = 7'h7f;
            #1;
            check_held(b, tag, left);
        end
        @(negedge clk);
        #1;
        chk(err_pulse == 1'b0 && all_valid() == '0, tag, "R7 single-cycle error / R6 no repeat",
            64'({err_pulse, all_valid()}), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(all_valid() == '0, "R1", "reset valids", 64'(all_valid()), 64'd0);
        chk(err_pulse == 1'b0, "R1", "reset error", 64'(err_pulse), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'd1);

        // R5: bundle of only empty slots
        run_one(make_bundle(0, 0, 0, 0, 0), 7'h00, "R5");
        // mixed memory-heavy bundle, all ready
        run_one(make_bundle(2, 3, 2, 4, 1), 7'h7f, "R3");
        // two scalars out of order with empty slots between: R4
        run_one(make_bundle(0, 1, 0, 0, 1), 7'h7f, "R4");
        // single missing ready stalls everything: R6
        run_one(make_bundle(1, 2, 5, 4, 3), 7'h5f, "R6");
        // illegal code: R7
        run_one(make_bundle(1, 6, 2, 0, 0), 7'h7f, "R7");
        run_one(make_bundle(7, 0, 0, 0, 0), 7'h7f, "R7");
        // over-subscription: three scalars, two stores: R8
        run_one(make_bundle(1, 1, 0, 1, 0), 7'h7f, "R8");
        run_one(make_bundle(3, 0, 3, 0, 0), 7'h7f, "R8");

        // R2/R9: second bundle offered while the first is stalled
        begin
            logic [159:0] ba, bb;
            bit left;
            ba = make_bundle(1, 4, 0, 0, 0);
            bb = make_bundle(5, 2, 2, 0, 1);
            @(negedge clk);
            in_bundle = ba; in_valid = 1'b1; rdy = 7'h00;
            @(negedge clk);
            in_bundle = bb;
            #1;
            chk(in_ready == 1'b0, "R2", "busy refuses input", 64'(in_ready), 64'd0);
            chk(all_valid() == '0, "R2", "stalled valids", 64'(all_valid()), 64'd0);
            @(negedge clk);
            rdy = 7'h7f;
            model(ba);
            #1;
            check_held(ba, "R9", left);
            @(negedge clk);
            in_valid = 1'b0;
            model(bb);
            #1;
            check_held(bb, "R9", left);
            @(negedge clk);
        end

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [6:0] fr;
            fr = ($urandom % 2) ? 7'h7f : 7'($urandom);
            run_one(rand_bundle(), fr, "R3");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule